// File: doc/BRIEF.md
# Predict-Taken Branch Redirect Controller

This block steers instruction fetch in a five-stage in-order pipeline that predicts every conditional branch as taken. When a live branch sits in the decode stage, the block adds the sign-extended, word-scaled displacement to the branch's in-line address (the incremented PC) and loads the result into the fetch PC at the end of that cycle. The in-line instruction fetched in that same cycle is discarded, so every branch costs one bubble.

In the following cycle the branch sits in execute, where its condition is resolved. A taken outcome means the guess was right, and fetch simply carries on down the target path. A not-taken outcome means the target instruction being fetched in that cycle is squashed, and the fetch PC is reloaded with the in-line address. That address was captured when the branch left decode, so it does not have to be recomputed. The block keeps its own record of which decode and execute slots hold squashed instructions, so a wrong-path instruction can never start a redirect. The surrounding pipeline uses the stall and flush outputs to turn the instruction being fetched into a NOP.

Top module: `pt_early_target_unit`

## Requirements
- R1: While reset is low and in the first cycle after it, fetch_pc_o equals RESET_PC, and stall_o and flush_o are 0, whatever the inputs.
- R2: When a live branch is in decode, next_pc_o equals id_pc4_i plus the sign-extended id_disp_i shifted left by 2, and fetch_pc_o takes that value at the next clock edge.
- R3: A live branch in decode raises stall_o for exactly that one cycle, which squashes the in-line instruction being fetched. The squashed slot never raises stall_o in the following cycle.
- R4: When the branch reaches execute and ex_taken_i is 0, flush_o is 1, and next_pc_o equals the id_pc4_i value that came with that branch in decode.
- R5: When the branch in execute has ex_taken_i at 1, flush_o stays 0, and the target instruction is kept. The next kept fetch after a taken branch comes 2 cycles after the branch was fetched, a penalty of 1 cycle.
- R6: For a not-taken branch, the next kept fetch is the branch's in-line address, 3 cycles after the branch was fetched, a penalty of 2 cycles.
- R7: id_is_branch_i in a decode slot that was squashed, or empty after reset, is ignored. ex_taken_i is ignored unless a live branch is in execute.
- R8: With neither stall nor flush, next_pc_o equals fetch_pc_o plus 4.
- R9: stall_o and flush_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| id_is_branch_i | input | 1 | Decode stage holds a conditional branch (raw decode, not gated by validity) |
| id_pc4_i | input | ADDR_W | In-line address (branch PC + 4) of the decode-stage instruction |
| id_disp_i | input | DISP_W | Signed word displacement of the decode-stage branch |
| ex_taken_i | input | 1 | Branch condition evaluated in execute is true |
| fetch_pc_o | output | ADDR_W | Address fetched in this cycle |
| next_pc_o | output | ADDR_W | Address to be fetched in the next cycle |
| stall_o | output | 1 | Squash the in-line instruction fetched this cycle (target being formed) |
| flush_o | output | 1 | Squash the target instruction fetched this cycle (prediction wrong) |

## Verification
A wrong slot-validity bit shows up in the same cycle as a stray or missing stall_o or flush_o. One cycle later it shows up as a fetch_pc_o that jumps where the reference stream does not. A bad target sum or a lost in-line address shows up on next_pc_o in that cycle and on fetch_pc_o at the next edge. A wrong penalty shows up as a gap between kept fetches that differs from 1, 2 or 3 cycles for a plain instruction, a taken branch or a not-taken branch. Sweeps of all-taken, all-not-taken, mixed and back-to-back branch programs check every kept fetch against an architectural model of the stream.

// File: rtl/pt_pkg.sv
package pt_pkg;

    // Source of the address fetched in the next cycle.
    typedef enum logic [1:0] {
        SEL_SEQ     = 2'd0,
        SEL_TARGET  = 2'd1,
        SEL_RECOVER = 2'd2
    } pc_sel_e;

endpackage

// File: rtl/pt_target_gen.sv
module pt_target_gen #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int SHIFT  = 2
) (
    input  logic [ADDR_W-1:0] pc4_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [ADDR_W-1:0] target_o
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;

    always_comb begin
        disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
        target_o = pc4_i + (disp_ext << SHIFT);
    end
endmodule

// File: rtl/pt_redirect_ctl.sv
module pt_redirect_ctl
    import pt_pkg::*;
(
    input  logic    id_br_live_i,
    input  logic    ex_br_live_i,
    input  logic    ex_taken_i,
    output logic    stall_o,
    output logic    flush_o,
    output pc_sel_e sel_o
);
    always_comb begin
        flush_o = ex_br_live_i && !ex_taken_i;
        stall_o = id_br_live_i && !flush_o;
        if (flush_o) begin
            sel_o = SEL_RECOVER;
        end else if (stall_o) begin
            sel_o = SEL_TARGET;
        end else begin
            sel_o = SEL_SEQ;
        end
    end
endmodule

// File: rtl/pt_pc_mux.sv
module pt_pc_mux
    import pt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  pc_sel_e           sel_i,
    input  logic [ADDR_W-1:0] seq_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic [ADDR_W-1:0] recover_i,
    output logic [ADDR_W-1:0] next_o
);
    always_comb begin
        case (sel_i)
            SEL_TARGET:  next_o = target_i;
            SEL_RECOVER: next_o = recover_i;
            default:     next_o = seq_i;
        endcase
    end
endmodule

// File: rtl/pt_early_target_unit.sv
module pt_early_target_unit
    import pt_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter int              DISP_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_is_branch_i,
    input  logic [ADDR_W-1:0] id_pc4_i,
    input  logic [DISP_W-1:0] id_disp_i,
    input  logic              ex_taken_i,
    output logic [ADDR_W-1:0] fetch_pc_o,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic              stall_o,
    output logic              flush_o
);
    localparam int INSTR_BYTES = 4;
    localparam int WORD_SHIFT  = $clog2(INSTR_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;       // fetch address
        logic              id_live;  // decode slot holds a kept instruction
        logic              ex_br;    // live branch now in execute
        logic [ADDR_W-1:0] ex_pc4;   // in-line address carried with it
    } state_t;

    state_t            st_q, st_d;
    logic              id_br_live;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] seq_pc;
    pc_sel_e           sel;

    assign id_br_live = id_is_branch_i && st_q.id_live;
    assign seq_pc     = st_q.pc + ADDR_W'(INSTR_BYTES);

    pt_target_gen #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W),
        .SHIFT  (WORD_SHIFT)
    ) target_i (
        .pc4_i    (id_pc4_i),
        .disp_i   (id_disp_i),
        .target_o (target)
    );

    pt_redirect_ctl ctl_i (
        .id_br_live_i (id_br_live),
        .ex_br_live_i (st_q.ex_br),
        .ex_taken_i   (ex_taken_i),
        .stall_o      (stall_o),
        .flush_o      (flush_o),
        .sel_o        (sel)
    );

    pt_pc_mux #(
        .ADDR_W (ADDR_W)
    ) mux_i (
        .sel_i     (sel),
        .seq_i     (seq_pc),
        .target_i  (target),
        .recover_i (st_q.ex_pc4),
        .next_o    (next_pc_o)
    );

    always_comb begin
        st_d         = st_q;
        st_d.pc      = next_pc_o;
        st_d.id_live = !(stall_o || flush_o);
        st_d.ex_br   = id_br_live;
        if (id_br_live) begin
            st_d.ex_pc4 = id_pc4_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc      <= RESET_PC;
            st_q.id_live <= 1'b0;
            st_q.ex_br   <= 1'b0;
            st_q.ex_pc4  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_pc_o = st_q.pc;
endmodule

// File: rtl/pt_early_target_chk.sv
module pt_early_target_chk #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] id_pc4_i,
    input logic [DISP_W-1:0] id_disp_i,
    input logic [ADDR_W-1:0] fetch_pc_o,
    input logic [ADDR_W-1:0] next_pc_o,
    input logic              stall_o,
    input logic              flush_o
);
    logic [ADDR_W-1:0] tgt_w;

    always_comb begin
        tgt_w = id_pc4_i + ({{(ADDR_W-DISP_W){id_disp_i[DISP_W-1]}}, id_disp_i} << 2);
    end

    assert_never_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall_o && flush_o));

    assert_one_bubble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !stall_o);

    assert_target_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> next_pc_o == tgt_w);

    assert_target_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> fetch_pc_o == $past(tgt_w));

    assert_recover_inline_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> fetch_pc_o == $past(id_pc4_i, 2));

    assert_flush_after_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> $past(stall_o));

    assert_sequential_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && !flush_o) |=> fetch_pc_o == $past(fetch_pc_o) + ADDR_W'(4));
endmodule

bind pt_early_target_unit pt_early_target_chk #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .id_pc4_i   (id_pc4_i),
    .id_disp_i  (id_disp_i),
    .fetch_pc_o (fetch_pc_o),
    .next_pc_o  (next_pc_o),
    .stall_o    (stall_o),
    .flush_o    (flush_o)
);

// File: tb/pt_early_target_unit_tb.sv
module pt_early_target_unit_tb_top;
    localparam logic [31:0] RST_PC = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        id_is_branch_i;
    logic [31:0] id_pc4_i;
    logic [15:0] id_disp_i;
    logic        ex_taken_i;
    logic [31:0] fetch_pc_o;
    logic [31:0] next_pc_o;
    logic        stall_o;
    logic        flush_o;

    int checks = 0;
    int fails  = 0;
    int mode   = 0;

    always #4 clk = ~clk;

    pt_early_target_unit dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .id_is_branch_i (id_is_branch_i),
        .id_pc4_i       (id_pc4_i),
        .id_disp_i      (id_disp_i),
        .ex_taken_i     (ex_taken_i),
        .fetch_pc_o     (fetch_pc_o),
        .next_pc_o      (next_pc_o),
        .stall_o        (stall_o),
        .flush_o        (flush_o)
    );

    // Synthetic program: branch placement, displacement and outcome per address.
    function automatic bit is_br(input logic [31:0] pc);
        int unsigned w = pc >> 2;
        if (mode == 3) return (w % 2) == 0;
        return (w % 3) == 1;
    endfunction

    function automatic bit taken(input logic [31:0] pc);
        int unsigned w = pc >> 2;
        case (mode)
            0: return 1'b1;
            1: return 1'b0;
            2: return ((w * 7 + 3) % 5) < 3;
            default: return (w % 3) != 0;
        endcase
    endfunction

    function automatic logic [15:0] disp_of(input logic [31:0] pc);
        int unsigned w = pc >> 2;
        int d = int'((w * 5) % 9) - 4;
        return 16'(d);
    endfunction

    function automatic logic [31:0] target_of(input logic [31:0] pc);
        int d = int'((32'(pc >> 2) * 5) % 9) - 4;
        return pc + 32'd4 + 32'(d * 4);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_pass(input int m);
        logic [31:0] ifid_pc, idex_pc, ref_pc;
        bit          ifid_v, idex_v, exp_stall, exp_flush;
        int          cyc, commits, last_cyc, exp_gap;
        string       gap_req;
        mode = m;
        rst_n = 1'b0;
        id_is_branch_i = 1'b1;
        id_pc4_i = 32'h0;
        id_disp_i = 16'h0;
        ex_taken_i = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        // R1: during reset the fetch PC is the reset address, no stall or flush
        chk(fetch_pc_o == RST_PC, "R1", "fetch pc in reset", fetch_pc_o, RST_PC);
        chk(!stall_o && !flush_o, "R1", "stall/flush in reset", {30'd0, stall_o, flush_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        ifid_v = 1'b0; idex_v = 1'b0;
        ifid_pc = RST_PC; idex_pc = RST_PC;
        ref_pc = RST_PC;
        cyc = 0; commits = 0; last_cyc = 0; exp_gap = 1; gap_req = "R8";
        while (commits < 48 && cyc < 400) begin
            id_is_branch_i = is_br(ifid_pc);
            id_pc4_i       = ifid_pc + 32'd4;
            id_disp_i      = disp_of(ifid_pc);
            ex_taken_i     = taken(idex_pc);
            #1;
            if (cyc == 0) begin
                chk(fetch_pc_o == RST_PC, "R1", "first fetch pc", fetch_pc_o, RST_PC);
                chk(!stall_o && !flush_o, "R1", "first cycle stall/flush", {30'd0, stall_o, flush_o}, 32'd0);
            end
            exp_stall = ifid_v && is_br(ifid_pc);
            exp_flush = idex_v && is_br(idex_pc) && !taken(idex_pc);
            // R3/R7: stall only for a live decode branch
            chk(stall_o == exp_stall, "R3/R7", "stall", {31'd0, stall_o}, {31'd0, exp_stall});
            // R4/R7: flush only for a live not-taken branch in execute
            chk(flush_o == exp_flush, "R4/R7", "flush", {31'd0, flush_o}, {31'd0, exp_flush});
            chk(!(stall_o && flush_o), "R9", "stall with flush", {30'd0, stall_o, flush_o}, 32'd0);
            if (exp_stall)
                chk(next_pc_o == target_of(ifid_pc), "R2", "target", next_pc_o, target_of(ifid_pc));
            else if (exp_flush)
                chk(next_pc_o == idex_pc + 32'd4, "R4", "recovery pc", next_pc_o, idex_pc + 32'd4);
            else
                chk(next_pc_o == fetch_pc_o + 32'd4, "R8", "sequential pc", next_pc_o, fetch_pc_o + 32'd4);
            if (!stall_o && !flush_o) begin
                // kept fetch: compare with the architectural stream and spacing
                chk(fetch_pc_o == ref_pc, "R5/R6/R8", "kept fetch pc", fetch_pc_o, ref_pc);
                if (commits > 0)
                    chk(cyc - last_cyc == exp_gap, gap_req, "fetch gap",
                        32'(cyc - last_cyc), 32'(exp_gap));
                if (is_br(ref_pc) && taken(ref_pc)) begin
                    exp_gap = 2; gap_req = "R5"; ref_pc = target_of(ref_pc);
                end else if (is_br(ref_pc)) begin
                    exp_gap = 3; gap_req = "R6"; ref_pc = ref_pc + 32'd4;
                end else begin
                    exp_gap = 1; gap_req = "R8"; ref_pc = ref_pc + 32'd4;
                end
                last_cyc = cyc;
                commits++;
            end
            idex_v  = ifid_v;
            idex_pc = ifid_pc;
            ifid_v  = !(stall_o || flush_o);
            ifid_pc = fetch_pc_o;
            cyc++;
            @(negedge clk);
        end
        chk(commits == 48, "R5/R6", "kept fetches in pass", 32'(commits), 32'd48);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int m = 0; m < 4; m++) run_pass(m);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule